// File: doc/BRIEF.md
# Mixed Edge/Level Interrupt Controller

This block gathers 32 interrupt sources into one request line for the CPU. Each source position is either level-sensitive, in which case its status bit simply follows the synchronised input, or edge-sensitive, in which case a rising edge sets a sticky latch that only software can clear. Three positions (4, 5 and 6) are not taken from the pin vector: they carry the summary requests of a secondary peripheral aggregator, supplied on a separate cascade input.

Software talks to the block through a single-cycle register port with four word addresses: a read-only status word, a read/write enable mask, the latched-source register, and a software-interrupt register. An edge latch is cleared by reading the latched-source register, zeroing the wanted bit and writing the word back. Bits 28 to 30 can also be raised by software through the software-interrupt register. The CPU request is the registered OR of status ANDed with the mask.

Top module: `mixed_irq_ctrl`

## Requirements
- R1: While reset is applied and right after it, the mask (address 1), latched-source (address 2) and software-interrupt (address 3) registers read zero and irq_o is low.
- R2: Level positions (every bit other than 16-19, 22-24 and 28-30) show the input on the status word (address 0) after a two-flop synchroniser, and drop again when the input drops.
- R3: Edge positions 16-19, 22-24 and 28-30 set on a rising edge of their synchronised input and stay set on status and on the latched-source register after the input falls, as long as no clear is written.
- R4: A write to the latched-source register clears every edge latch whose write-data bit is 0 and leaves those whose bit is 1 unchanged; writing a 1 never sets a latch.
- R5: When a rising edge is detected in the same cycle as a write that clears that bit, the latch ends up set.
- R6: Writes to the latched-source register do not alter level positions of the status word, and level positions of the latched-source register always read zero.
- R7: Status bits 4, 5 and 6 follow cascade inputs 0, 1 and 2 respectively; pin inputs 4 to 6 have no effect.
- R8: irq_o equals the OR of (status AND mask) with one register stage of delay.
- R9: The software-interrupt register stores only bits 28-30 (other bits read zero); each stored bit is ORed into its source, so writing a 1 over a 0 produces a rising edge that latches the matching status bit, and clearing the latch while the bit stays 1 does not re-latch it.
- R10: The enable mask holds and reads back all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 32 | Asynchronous interrupt source pins (bits 4-6 unused) |
| casc_i | input | 3 | Summary requests of the secondary aggregator, mapped to bits 4-6 |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | 2 | Register select: 0 status, 1 mask, 2 latched sources, 3 software interrupts |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the selected register (combinational) |
| irq_o | output | 1 | Registered interrupt request to the CPU |

## Verification
The properties take for granted that the synchronised source vector is the only thing that sets a latch besides software, that each write strobe lasts one cycle with a valid address, and that a clear and a new edge can coincide only through the synchroniser timing. The stimulus respects this by changing pins and write signals only on the falling clock edge, returning all sources to zero and waiting out the synchroniser before each table vector so every edge bit sees a clean rising edge, and staging the clear-versus-set race by counting the two synchroniser stages exactly.

// File: rtl/mirq_pkg.sv
package mirq_pkg;
  localparam int unsigned NSRC_DEF     = 32;
  localparam logic [31:0] EDGE_BITS_DEF = 32'h71CF_0000;
  localparam logic [31:0] SOFT_BITS_DEF = 32'h7000_0000;
  localparam int unsigned CASC_LSB_DEF = 4;
  localparam int unsigned CASC_W_DEF   = 3;
  localparam int unsigned ADDR_W       = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_LATCH  = 2'd2,
    SEL_SOFT   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/mirq_sync.sv
module mirq_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stage_d[s] = d_i;
    end else begin : g_next
      assign stage_d[s] = stage_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_d[s];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/mirq_src_bank.sv
module mirq_src_bank #(
  parameter int unsigned    NSRC      = 32,
  parameter logic [NSRC-1:0] EDGE_BITS = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] in_i,
  input  logic            clr_en_i,
  input  logic [NSRC-1:0] keep_i,
  output logic [NSRC-1:0] status_o,
  output logic [NSRC-1:0] latch_o,
  output logic [NSRC-1:0] edge_o
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (EDGE_BITS[i]) begin : g_edge
      logic prev_q, prev_d, lat_q, lat_d;

      always_comb begin
        prev_d = in_i[i];
        lat_d  = lat_q;
        if (clr_en_i && !keep_i[i]) lat_d = 1'b0;
        // a fresh edge overrides a clear in the same cycle
        if (in_i[i] && !prev_q)     lat_d = 1'b1;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          prev_q <= 1'b0;
          lat_q  <= 1'b0;
        end else begin
          prev_q <= prev_d;
          lat_q  <= lat_d;
        end
      end

      assign edge_o[i]   = in_i[i] & ~prev_q;
      assign status_o[i] = lat_q;
      assign latch_o[i]  = lat_q;
    end else begin : g_level
      assign edge_o[i]   = 1'b0;
      assign status_o[i] = in_i[i];
      assign latch_o[i]  = 1'b0;
    end
  end
endmodule

// File: rtl/mixed_irq_ctrl.sv
module mixed_irq_ctrl
  import mirq_pkg::*;
#(
  parameter int unsigned     NSRC        = NSRC_DEF,
  parameter int unsigned     SYNC_STAGES = 2,
  parameter int unsigned     CASC_LSB    = CASC_LSB_DEF,
  parameter int unsigned     CASC_W      = CASC_W_DEF,
  parameter logic [NSRC-1:0] EDGE_BITS   = EDGE_BITS_DEF,
  parameter logic [NSRC-1:0] SOFT_BITS   = SOFT_BITS_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_i,
  input  logic [CASC_W-1:0] casc_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NSRC-1:0]   wdata_i,
  output logic [NSRC-1:0]   rdata_o,
  output logic              irq_o
);
  localparam logic [NSRC-1:0] CASC_ONES = NSRC'((64'd1 << CASC_W) - 64'd1);
  localparam logic [NSRC-1:0] CASC_MASK = CASC_ONES << CASC_LSB;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // source merge: cascade summaries replace pins at their positions
  logic [NSRC-1:0] raw_w, sync_w, eff_w;
  assign raw_w = (src_i & ~CASC_MASK) | ((NSRC'(casc_i) << CASC_LSB) & CASC_MASK);

  mirq_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .d_i   (raw_w),
    .q_o   (sync_w)
  );

  // register write decode
  logic wr_mask, wr_latch, wr_soft;
  assign wr_mask  = wr_en_i && (addr_i == SEL_MASK);
  assign wr_latch = wr_en_i && (addr_i == SEL_LATCH);
  assign wr_soft  = wr_en_i && (addr_i == SEL_SOFT);

  logic [NSRC-1:0] mask_q, mask_d, soft_q, soft_d;
  logic            irq_d;

  always_comb begin
    mask_d = mask_q;
    soft_d = soft_q;
    if (wr_mask) mask_d = wdata_i;
    if (wr_soft) soft_d = wdata_i & SOFT_BITS;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      soft_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      soft_q <= soft_d;
      irq_o  <= irq_d;
    end
  end

  assign eff_w = sync_w | soft_q;

  logic [NSRC-1:0] status_w, latch_w, edge_w;
  mirq_src_bank #(.NSRC(NSRC), .EDGE_BITS(EDGE_BITS)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .in_i    (eff_w),
    .clr_en_i(wr_latch),
    .keep_i  (wdata_i),
    .status_o(status_w),
    .latch_o (latch_w),
    .edge_o  (edge_w)
  );

  assign irq_d = |(status_w & mask_q);

  always_comb begin
    unique case (reg_sel_e'(addr_i))
      SEL_STATUS: rdata_o = status_w;
      SEL_MASK:   rdata_o = mask_q;
      SEL_LATCH:  rdata_o = latch_w;
      SEL_SOFT:   rdata_o = soft_q;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mixed_irq_ctrl_chk.sv
module mixed_irq_ctrl_chk #(
  parameter int unsigned NSRC = 32
) (
  input logic            clk_i,
  input logic            rst_n,
  input logic            wr_latch,
  input logic [NSRC-1:0] wdata_i,
  input logic [NSRC-1:0] edge_w,
  input logic [NSRC-1:0] latch_w,
  input logic [NSRC-1:0] status_w,
  input logic [NSRC-1:0] mask_q,
  input logic [NSRC-1:0] soft_q,
  input logic            irq_o
);
  // R1
  always @(posedge clk_i) begin
    if (rst_n === 1'b0) begin
      reset_clear_chk: assert (mask_q == '0 && soft_q == '0 && latch_w == '0 && irq_o == 1'b0);
    end
  end

  // R8
  irq_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o == |($past(status_w & mask_q)));

  // R3
  latch_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !wr_latch |=> (($past(latch_w) & ~latch_w) == '0));

  // R4
  latch_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr_latch |=> ((latch_w & ~$past(wdata_i) & ~$past(edge_w)) == '0));

  // R5
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (edge_w != '0) |=> ((latch_w & $past(edge_w)) == $past(edge_w)));
endmodule

bind mixed_irq_ctrl mixed_irq_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk_i   (clk_i),
  .rst_n   (rst_n),
  .wr_latch(wr_latch),
  .wdata_i (wdata_i),
  .edge_w  (edge_w),
  .latch_w (latch_w),
  .status_w(status_w),
  .mask_q  (mask_q),
  .soft_q  (soft_q),
  .irq_o   (irq_o)
);

// File: tb/tb_mixed_irq_ctrl.sv
module tb_mixed_irq_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [31:0] src_i;
  logic [2:0]  casc_i;
  logic        wr_en_i;
  logic [1:0]  addr_i;
  logic [31:0] wdata_i;
  logic [31:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  mixed_irq_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .casc_i(casc_i),
    .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [31:0] src;
    logic [2:0]  casc;
    logic [31:0] mask;
    logic [31:0] st;
    logic        irq;
  } vec_t;

  // addresses: 0 status, 1 mask, 2 latched sources, 3 software
  localparam vec_t VEC [6] = '{
    '{32'h0000_0001, 3'b000, 32'h0000_0001, 32'h0000_0001, 1'b1}, // R2 R8
    '{32'h0001_0000, 3'b000, 32'h0001_0000, 32'h0001_0000, 1'b1}, // R3 R8
    '{32'h0000_0070, 3'b000, 32'h0000_0070, 32'h0000_0000, 1'b0}, // R7
    '{32'h0000_0000, 3'b101, 32'h0000_0020, 32'h0000_0050, 1'b0}, // R7 R8
    '{32'h8E00_0F00, 3'b010, 32'hFFFF_FFFF, 32'h8E00_0F20, 1'b1}, // R2 R7
    '{32'hFFFF_FFFF, 3'b111, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0}  // R3 R8
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk_i);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog got=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_ni = 1'b0; src_i = '0; casc_i = '0; wr_en_i = 1'b0; addr_i = '0; wdata_i = '0;
    wait_cyc(4);
    rst_ni = 1'b1;
    wait_cyc(4);

    // R1 reset state
    rd(2'd1, v); check("R1 mask", v, 32'h0);
    rd(2'd2, v); check("R1 latch", v, 32'h0);
    rd(2'd3, v); check("R1 soft", v, 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);

    // vector table
    for (int i = 0; i < 6; i++) begin
      src_i = '0; casc_i = '0;
      wait_cyc(5);
      wr(2'd2, 32'h0);
      wr(2'd1, VEC[i].mask);
      src_i = VEC[i].src; casc_i = VEC[i].casc;
      wait_cyc(6);
      rd(2'd0, v); check("R2/R3/R7 status", v, VEC[i].st);
      check("R8 irq", {31'b0, irq_o}, {31'b0, VEC[i].irq});
    end
    src_i = '0; casc_i = '0;
    wait_cyc(5);
    wr(2'd2, 32'h0);

    // R10 mask readback
    wr(2'd1, 32'hA5A5_5A5A);
    rd(2'd1, v); check("R10 mask", v, 32'hA5A5_5A5A);
    wr(2'd1, 32'h0);

    // R3 sticky after input falls; R2 level drops
    src_i = 32'h0002_0100;
    wait_cyc(5);
    src_i = '0;
    wait_cyc(5);
    rd(2'd0, v); check("R3 sticky/R2 level drop", v, 32'h0002_0000);
    rd(2'd2, v); check("R3 latch reg", v, 32'h0002_0000);

    // R4 write-back clear, bit 18 kept
    src_i = 32'h0004_0000; wait_cyc(5); src_i = '0; wait_cyc(4);
    wr(2'd2, ~32'h0002_0000);
    rd(2'd2, v); check("R4 clear one keep other", v, 32'h0004_0000);
    wr(2'd2, 32'h0);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v); check("R4 ones do not set", v, 32'h0);

    // R6 level bit untouched by latch writes
    src_i = 32'h0000_0004; wait_cyc(5);
    wr(2'd2, 32'h0);
    rd(2'd0, v); check("R6 level status kept", v, 32'h0000_0004);
    rd(2'd2, v); check("R6 latch level reads zero", v, 32'h0);
    src_i = '0; wait_cyc(5);

    // R5 edge and clear in the same cycle
    @(negedge clk_i);
    src_i = 32'h0080_0000;
    @(posedge clk_i);
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = 2'd2; wdata_i = 32'h0;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    rd(2'd2, v); check("R5 set wins", v, 32'h0080_0000);
    src_i = '0; wait_cyc(5);
    wr(2'd2, 32'h0);

    // R9 software interrupts
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v); check("R9 soft bits", v, 32'h7000_0000);
    wr(2'd1, 32'h2000_0000);
    wait_cyc(3);
    rd(2'd0, v); check("R9 soft latched", v, 32'h7000_0000);
    check("R9 irq", {31'b0, irq_o}, 32'h1);
    wr(2'd2, 32'h0);
    wait_cyc(3);
    rd(2'd0, v); check("R9 no relatch", v, 32'h0);
    wr(2'd3, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule